// File: doc/BRIEF.md
# Manchester Line Decoder with Lock Detection

This block takes one self-clocked Manchester line, where clock and data share a single wire as the exclusive-OR of the NRZ bit and the bit clock, and recovers the data bits from it. A local clock samples the line at sixteen times the nominal bit rate. The line passes through a two-stage synchroniser, and the decoder then looks for the transition that every bit cell carries at its midpoint. The direction of that transition gives the bit. The same edge realigns the bit timing.

Edges that arrive soon after a mid-cell edge are cell-boundary edges and are discarded. The decoder claims lock only after a run of correctly spaced mid-cell edges. It gives up lock when the line stops toggling. Losing lock sets a sticky error flag, and the decoder then searches for timing again from scratch. Each decoded bit appears with a one-cycle valid strobe, and strobes are issued only while locked.

Top module: `manchester_rx`

## Requirements
- R1: While rst_n is low at a clock edge, locked, bit_valid and sync_err are all 0 after that edge.
- R2: A mid-cell edge from low to high decodes as bit_out = 0, and one from high to low decodes as bit_out = 1. A 0 cell is therefore low in its first half and high in its second.
- R3: An edge arriving fewer than 12 sample cycles (three quarters of a bit) after the last accepted mid-cell edge is ignored. The next edge after that window is taken as the next mid-cell edge.
- R4: An accepted edge whose distance from the previous accepted edge is 12 to 20 sample cycles counts as well spaced. The first edge after an idle line never counts. locked rises after 8 consecutive well-spaced edges, so from an idle line the 10th bit (index 9) is the first one strobed.
- R5: bit_valid is never high while locked is low, and no bit is strobed for a burst too short to gain lock.
- R6: Mid-to-boundary half cells that deviate by up to ±2 sample cycles (±12.5 % of a bit) still decode every locked bit correctly.
- R7: If no edge is accepted for 32 sample cycles (two bit periods), locked goes low and the search for timing restarts.
- R8: sync_err goes high when lock is lost through R7 and stays high until reset, including across later reacquisition. A burst that never locks does not set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock at 16 times the bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 1 | Asynchronous Manchester line |
| bit_out | output | 1 | Most recently decoded bit |
| bit_valid | output | 1 | One-cycle strobe marking a new bit_out while locked |
| locked | output | 1 | Bit timing acquired |
| sync_err | output | 1 | Sticky flag: lock was lost for lack of transitions |

## Verification
The edge that completes the lock streak is also a decode event. In one cycle it both raises locked and produces a bit. That bit must not be strobed, while the next one must be. The bench provokes this at the start of every burst from an idle line and queues expectations only from bit index 9 onward. Any off-by-one between lock and the strobe gate then shows up either as an unexpected strobe with an empty queue or as a misaligned bit. In the same way, the loss-of-lock timeout and the sticky error share a cycle. The bench judges this after a burst ends by checking locked, sync_err and an empty queue together.

// File: rtl/mdec_pkg.sv
// Shared types for the Manchester decoder.
// Assumes: single sample-clock domain downstream of the synchroniser.
package mdec_pkg;

    // Qualified line transition seen on one sample cycle
    typedef struct packed {
        logic rise;
        logic fall;
    } line_edge_t;

endpackage

// File: rtl/mdec_sync.sv
// Two-stage synchroniser for the raw line plus an edge detector.
// Assumes: line_in is asynchronous to clk; output edges are one cycle wide.
module mdec_sync #(
    parameter int STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_in,
    output mdec_pkg::line_edge_t  edg
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // shift the raw line through the synchroniser and keep one older sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], line_in};
            prev  <= chain[STAGES-1];
        end
    end

    // classify the transition between the two newest synchronised samples
    always_comb begin
        edg.rise = chain[STAGES-1] & ~prev;
        edg.fall = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/mdec_timing.sv
// Bit-cell timer: accepts mid-cell edges outside the blanking window, grades
// their spacing, detects starvation and latches the decoded bit.
// Assumes: OVS samples per bit; counter idles saturated at the loss limit.
module mdec_timing #(
    parameter int OVS       = 16,
    parameter int LOSS_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  mdec_pkg::line_edge_t  edg,
    output logic                  accept,
    output logic                  good,
    output logic                  timeout,
    output logic                  bit_q
);
    localparam int LIMIT = LOSS_BITS * OVS;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam int BLANK = (OVS * 3) / 4;
    localparam int LO    = OVS - OVS / 4;
    localparam int HI    = OVS + OVS / 4;

    logic [CW-1:0] cnt;
    logic          any_edge;

    // qualify edges against the blanking window and the spacing window
    always_comb begin
        any_edge = edg.rise | edg.fall;
        accept   = any_edge && (cnt >= CW'(BLANK));
        good     = accept && (cnt >= CW'(LO)) && (cnt <= CW'(HI));
        timeout  = !accept && (cnt == CW'(LIMIT - 1));
    end

    // count samples since the last accepted edge, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= CW'(LIMIT);
        else if (accept)       cnt <= CW'(1);
        else if (cnt != CW'(LIMIT)) cnt <= cnt + CW'(1);
    end

    // decode the bit from the direction of the accepted edge
    always_ff @(posedge clk) begin
        if (!rst_n)      bit_q <= 1'b0;
        else if (accept) bit_q <= edg.fall;
    end

    // R3: nothing accepted right after an accepted edge
    p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
    // R7: a starvation pulse is followed by an idle (saturated) counter
    p_idle_after_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !good);
endmodule

// File: rtl/mdec_lock.sv
// Lock tracker: counts consecutive well-spaced mid-cell edges and drops lock
// on starvation.
// Assumes: accept, good and timeout come from the bit-cell timer, timeout
// never coincides with accept.
module mdec_lock #(
    parameter int LOCK_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic good,
    input  logic timeout,
    output logic locked,
    output logic lost
);
    localparam int SW = $clog2(LOCK_BITS + 1);

    logic [SW-1:0] streak;

    // flag a loss of lock in the cycle the timer starves
    always_comb lost = timeout && locked;

    // build the streak of good edges and set or clear lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            streak <= '0;
            locked <= 1'b0;
        end else if (timeout) begin
            streak <= '0;
            locked <= 1'b0;
        end else if (accept) begin
            if (good) begin
                if (streak != SW'(LOCK_BITS)) streak <= streak + SW'(1);
                if (streak == SW'(LOCK_BITS - 1)) locked <= 1'b1;
            end else begin
                streak <= '0;
            end
        end
    end

    // R4: lock is only ever gained on a well-spaced edge
    p_lock_on_good_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(good));
    // R7: lock is only ever dropped by starvation
    p_drop_on_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(timeout));
endmodule

// File: rtl/manchester_rx.sv
// Manchester line decoder top: synchroniser, bit-cell timer, lock tracker,
// output strobe and sticky loss-of-sync flag.
// Assumes: clk runs at OVS times the nominal bit rate.
module manchester_rx #(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_BITS   = 8,
    parameter int LOSS_BITS   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic bit_out,
    output logic bit_valid,
    output logic locked,
    output logic sync_err
);
    mdec_pkg::line_edge_t edg;
    logic accept, good, timeout, lost, bit_q;

    mdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .edg(edg)
    );

    mdec_timing #(.OVS(OVS), .LOSS_BITS(LOSS_BITS)) u_timing (
        .clk(clk), .rst_n(rst_n), .edg(edg), .accept(accept),
        .good(good), .timeout(timeout), .bit_q(bit_q)
    );

    mdec_lock #(.LOCK_BITS(LOCK_BITS)) u_lock (
        .clk(clk), .rst_n(rst_n), .accept(accept), .good(good),
        .timeout(timeout), .locked(locked), .lost(lost)
    );

    always_comb bit_out = bit_q;

    // strobe a decoded bit only when lock was already held
    always_ff @(posedge clk) begin
        if (!rst_n) bit_valid <= 1'b0;
        else        bit_valid <= accept && locked;
    end

    // remember any loss of lock until reset
    always_ff @(posedge clk) begin
        if (!rst_n)    sync_err <= 1'b0;
        else if (lost) sync_err <= 1'b1;
    end

    // R5: no strobe while unlocked
    p_valid_needs_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> locked);
    // R8: error flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> sync_err);
    // R3: strobes are separated by the blanking window
    p_valid_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);
endmodule

// File: tb/manchester_rx_test.sv
// Scoreboard bench: the driver queues expected bits, the monitor pops them
// on every strobe.
module manchester_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b0;
    logic bit_out, bit_valid, locked, sync_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic exp_q[$];

    always #2 clk = ~clk;

    manchester_rx uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .bit_out(bit_out),
        .bit_valid(bit_valid), .locked(locked), .sync_err(sync_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: every strobe must match the next queued bit
    always @(negedge clk) begin
        if (rst_n && bit_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 strobe with nothing expected", 1, 0);
            end else begin
                logic e;
                e = exp_q.pop_front();
                check(bit_out == e, "R2 decoded bit", int'(bit_out), int'(e));
            end
        end
    end

    // drive one cell: first half level = bit, second half = ~bit (R2 encoding)
    task automatic send_bit(input logic b, input int h1, input int h2);
        line_in = b;
        repeat (h1) @(posedge clk);
        #1 line_in = ~b;
        repeat (h2) @(posedge clk);
        #1;
    endtask

    // burst from an idle-low line; bits from index 9 are expected (R4)
    task automatic burst(input int n, input int seed, input bit jitter);
        for (int i = 0; i < n; i++) begin
            logic b;
            int h1, h2;
            b  = (i == 0) ? 1'b0 : logic'(((i * 5 + seed) ^ (i >> 1)) & 1);
            h1 = 8;
            h2 = 8;
            if (jitter) begin
                h1 = 8 + ((i % 5) - 2);
                h2 = 8 - (((i + 2) % 5) - 2);
            end
            if (i >= 9) exp_q.push_back(b);
            send_bit(b, h1, h2);
            if (i == 10) check(locked == 1'b1, "R4 locked after streak", int'(locked), 1);
        end
        // return to idle low, then let the line starve
        line_in = 1'b0;
        repeat (45) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(locked == 1'b0, "R1 locked in reset", int'(locked), 0);
        check(bit_valid == 1'b0, "R1 valid in reset", int'(bit_valid), 0);
        check(sync_err == 1'b0, "R1 error in reset", int'(sync_err), 0);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;

        // R5: too short to lock, no strobes, no error (R8)
        burst(7, 3, 1'b0);
        check(locked == 1'b0, "R5 short burst no lock", int'(locked), 0);
        check(sync_err == 1'b0, "R8 no error without lock", int'(sync_err), 0);

        // R2/R3/R4 nominal burst, then R7/R8 starvation
        burst(30, 1, 1'b0);
        check(exp_q.size() == 0, "R2 all bits strobed", exp_q.size(), 0);
        check(locked == 1'b0, "R7 lock lost on starvation", int'(locked), 0);
        check(sync_err == 1'b1, "R8 error set on loss", int'(sync_err), 1);

        // R6 timing deviation
        burst(40, 6, 1'b1);
        check(exp_q.size() == 0, "R6 jittered bits strobed", exp_q.size(), 0);
        check(sync_err == 1'b1, "R8 error still held", int'(sync_err), 1);

        // R3 all-same data: boundary edges every cell must be ignored
        for (int i = 0; i < 20; i++) begin
            if (i >= 9) exp_q.push_back(1'b0);
            send_bit(1'b0, 8, 8);
        end
        line_in = 1'b0;
        repeat (45) @(posedge clk);
        #1;
        check(exp_q.size() == 0, "R3 boundary edges ignored", exp_q.size(), 0);
        check(locked == 1'b0, "R7 lock lost again", int'(locked), 0);

        // R1 reset clears the sticky flag
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(sync_err == 1'b0, "R1 error cleared by reset", int'(sync_err), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule